// File: doc/BRIEF.md
# V.23 Line Turnaround Sequencer

This block sequences the exchange of the two V.23 channels in a half-duplex modem, so that the side sending on the slow 75 bps back channel takes over the 1200/600 bps forward channel, and the other way round. It is advanced by a 1 ms tick. It reads two qualified tone-present inputs, one for the low (390 Hz) tone and one for the high (1300 Hz) tone, and it drives a single transmit-carrier select. Tone detection, modulation and command parsing sit outside the block.

In master role the host starts a turnaround with a one-cycle command strobe. In slave role the block starts a reverse turnaround by itself when the received low tone stays absent for too long. Each listening phase opens a fixed window and adds up the ticks on which the expected tone is present. The tone does not need to be continuous. More than a threshold of accumulated tone means success. The slave side gets a second try with the carrier swapped back. Every outcome is reported as a one-cycle result strobe with a code. Slave outcomes also raise a sticky flag. A failed final window also pulses a hang-up request.

Top module: `v23_turn_ctrl`

## Requirements
- R1: `turn_cmd` starts a turnaround only when `role_master` is 1 and no procedure is running. In slave role it has no effect: `tx_hi_sel` stays unchanged and no result is reported.
- R2: An accepted master command sets `tx_hi_sel` to 1 (high tone) on the next clock. A window of WIN_FWD ticks (440 by default) then opens, in which `car_lo` is sampled on every tick.
- R3: When the master window closes with more than DET_MIN (40) accumulated ticks of `car_lo`, `res_valid` pulses with `res_code` = 1 (forward connect, 'c') in the cycle after the window's final tick. The ticks of tone need not be adjacent.
- R4: When the master window closes with DET_MIN or fewer ticks of tone (exactly 40 counts as a failure), `res_valid` pulses with `res_code` = 3 (no carrier, 'N'). `hangup` pulses in that same cycle, and `tx_hi_sel` returns to the value of `tx_fast`.
- R5: In slave role while idle, `car_lo` absent on DROP_MAX+1 (21) consecutive ticks sets `tx_hi_sel` to 0 on the next clock and opens a WIN_REV (400) tick window on `car_hi`. Any cycle with `car_lo` present restarts the drop count.
- R6: If the first slave window gathers more than DET_MIN ticks of `car_hi`, the block reports `res_code` = 2 (reverse connect, 'v') and sets `stat_flag`.
- R7: If the first slave window fails, `tx_hi_sel` goes back to 1 and a WIN_RETRY (440) tick window on `car_lo` opens. Success there reports `res_code` = 1 and sets `stat_flag`.
- R8: If the second slave window also fails, the block pulses `hangup`, sets `stat_flag` and reports `res_code` = 3.
- R9: `stat_flag` stays set until `flag_clr` is pulsed. A set in the same cycle as a clear wins.
- R10: `res_valid` is high for exactly one clock per finished procedure.
- R11: A successful turnaround sets `tx_fast` to the carrier select in use, and `rx_fast` to its inverse. A failed one leaves both unchanged. After reset `tx_fast`=0, `rx_fast`=1 and `tx_hi_sel`=0. While idle, `tx_hi_sel` equals `tx_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms time base pulse |
| turn_cmd | input | 1 | One-cycle master turnaround request |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| car_lo | input | 1 | Low (390 Hz) tone present |
| car_hi | input | 1 | High (1300 Hz) tone present |
| flag_clr | input | 1 | Clears the sticky status flag |
| tx_hi_sel | output | 1 | Transmit carrier: 1 = high tone, 0 = low tone |
| res_valid | output | 1 | Result strobe, one cycle |
| res_code | output | 2 | 1 = forward connect, 2 = reverse connect, 3 = no carrier |
| stat_flag | output | 1 | Sticky slave-result flag |
| hangup | output | 1 | One-cycle hang-up request |
| tx_fast | output | 1 | Transmit on forward (fast) channel |
| rx_fast | output | 1 | Receive on forward (fast) channel |

## Verification
The master window is tried with tone spread thinly on every tenth tick. This separates accumulated counting from any need for a continuous run. It is also tried with exactly the threshold amount, which separates "more than" from "at least". The slave path is driven with a carrier drop that recovers one tick before the limit, and then with one that reaches it, which pins down both the restart and the trigger tick. The three slave outcomes (success in the first window, success after the retry, failure in both) are each run, and each must produce a distinct code, flag and rate-bit pattern. A cycle-accurate behavioural model checks every output on every clock throughout.

// File: rtl/v23_turn_pkg.sv
package v23_turn_pkg;

    typedef enum logic [1:0] {
        PH_IDLE       = 2'd0,
        PH_FWD_WAIT   = 2'd1,
        PH_REV_WAIT   = 2'd2,
        PH_RETRY_WAIT = 2'd3
    } phase_e;

    localparam logic [1:0] RC_NONE  = 2'd0;
    localparam logic [1:0] RC_FWD   = 2'd1;
    localparam logic [1:0] RC_REV   = 2'd2;
    localparam logic [1:0] RC_NOCAR = 2'd3;

    typedef struct packed {
        phase_e     ph;
        logic       hi_sel;
        logic [1:0] code;
        logic       vld;
        logic       flag;
        logic       hup;
        logic       tx_fast;
        logic       rx_fast;
    } ctl_s;

endpackage

// File: rtl/v23_win_meter.sv
// Window timer plus tone-time accumulator, shared by all listening phases.
module v23_win_meter #(
    parameter int CW      = 9,
    parameter int DET_MIN = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          tick,
    input  logic          det,
    input  logic [CW-1:0] win_len,
    output logic          last,
    output logic          pass
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] acc;
    } mtr_s;

    mtr_s          m_d, m_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] acc_inc;

    always_comb begin
        m_d     = m_q;
        cnt_inc = m_q.cnt + 1'b1;
        acc_inc = m_q.acc + CW'(det);
        last    = en && tick && (cnt_inc == win_len);
        pass    = acc_inc > CW'(DET_MIN);
        if (clr) begin
            m_d = '0;
        end else if (en && tick) begin
            m_d.cnt = cnt_inc;
            m_d.acc = acc_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/v23_drop_timer.sv
// Counts consecutive ticks without the received tone; restarts on any return.
module v23_drop_timer #(
    parameter int DROP_MAX = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    input  logic carrier,
    output logic fire
);
    localparam int DW = $clog2(DROP_MAX + 2);

    logic [DW-1:0] cnt_d, cnt_q;
    logic [DW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        fire    = arm && tick && !carrier && (cnt_inc > DW'(DROP_MAX));
        cnt_d   = cnt_q;
        if (!arm || carrier || fire) cnt_d = '0;
        else if (tick)               cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/v23_turn_ctrl.sv
module v23_turn_ctrl
    import v23_turn_pkg::*;
#(
    parameter int WIN_FWD   = 440,
    parameter int WIN_REV   = 400,
    parameter int WIN_RETRY = 440,
    parameter int DET_MIN   = 40,
    parameter int DROP_MAX  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       turn_cmd,
    input  logic       role_master,
    input  logic       car_lo,
    input  logic       car_hi,
    input  logic       flag_clr,
    output logic       tx_hi_sel,
    output logic       res_valid,
    output logic [1:0] res_code,
    output logic       stat_flag,
    output logic       hangup,
    output logic       tx_fast,
    output logic       rx_fast
);
    localparam int WIN_A   = (WIN_FWD > WIN_REV) ? WIN_FWD : WIN_REV;
    localparam int WIN_MAX = (WIN_A > WIN_RETRY) ? WIN_A : WIN_RETRY;
    localparam int CW      = $clog2(WIN_MAX + 1);

    ctl_s          d, q;
    logic          win_clr, win_en, win_det, win_last, win_pass;
    logic [CW-1:0] win_len;
    logic          drop_arm, drop_fire;

    v23_win_meter #(.CW(CW), .DET_MIN(DET_MIN)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .en     (win_en),
        .tick   (tick_ms),
        .det    (win_det),
        .win_len(win_len),
        .last   (win_last),
        .pass   (win_pass)
    );

    v23_drop_timer #(.DROP_MAX(DROP_MAX)) u_drop (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (drop_arm),
        .tick   (tick_ms),
        .carrier(car_lo),
        .fire   (drop_fire)
    );

    always_comb begin
        win_en   = (q.ph != PH_IDLE);
        drop_arm = (q.ph == PH_IDLE) && !role_master;
        win_det  = (q.ph == PH_REV_WAIT) ? car_hi : car_lo;
        case (q.ph)
            PH_REV_WAIT:   win_len = CW'(WIN_REV);
            PH_RETRY_WAIT: win_len = CW'(WIN_RETRY);
            default:       win_len = CW'(WIN_FWD);
        endcase

        d       = q;
        d.vld   = 1'b0;
        d.hup   = 1'b0;
        win_clr = 1'b0;
        if (flag_clr) d.flag = 1'b0;

        case (q.ph)
            PH_IDLE: begin
                d.hi_sel = q.tx_fast;
                if (role_master && turn_cmd) begin
                    d.ph     = PH_FWD_WAIT;
                    d.hi_sel = 1'b1;
                    win_clr  = 1'b1;
                end else if (drop_fire) begin
                    d.ph     = PH_REV_WAIT;
                    d.hi_sel = 1'b0;
                    win_clr  = 1'b1;
                end
            end
            PH_FWD_WAIT: begin
                if (win_last) begin
                    d.ph  = PH_IDLE;
                    d.vld = 1'b1;
                    if (win_pass) begin
                        d.code    = RC_FWD;
                        d.tx_fast = q.hi_sel;
                        d.rx_fast = !q.hi_sel;
                    end else begin
                        d.code   = RC_NOCAR;
                        d.hup    = 1'b1;
                        d.hi_sel = q.tx_fast;
                    end
                end
            end
            PH_REV_WAIT: begin
                if (win_last) begin
                    if (win_pass) begin
                        d.ph      = PH_IDLE;
                        d.vld     = 1'b1;
                        d.flag    = 1'b1;
                        d.code    = RC_REV;
                        d.tx_fast = q.hi_sel;
                        d.rx_fast = !q.hi_sel;
                    end else begin
                        d.ph     = PH_RETRY_WAIT;
                        d.hi_sel = 1'b1;
                        win_clr  = 1'b1;
                    end
                end
            end
            PH_RETRY_WAIT: begin
                if (win_last) begin
                    d.ph   = PH_IDLE;
                    d.vld  = 1'b1;
                    d.flag = 1'b1;
                    if (win_pass) begin
                        d.code    = RC_FWD;
                        d.tx_fast = q.hi_sel;
                        d.rx_fast = !q.hi_sel;
                    end else begin
                        d.code   = RC_NOCAR;
                        d.hup    = 1'b1;
                        d.hi_sel = q.tx_fast;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.rx_fast <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_hi_sel = q.hi_sel;
    assign res_valid = q.vld;
    assign res_code  = q.code;
    assign stat_flag = q.flag;
    assign hangup    = q.hup;
    assign tx_fast   = q.tx_fast;
    assign rx_fast   = q.rx_fast;
endmodule

// File: rtl/v23_turn_ctrl_chk.sv
module v23_turn_ctrl_chk
    import v23_turn_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       turn_cmd,
    input logic       role_master,
    input logic       flag_clr,
    input logic       tx_hi_sel,
    input logic       res_valid,
    input logic [1:0] res_code,
    input logic       stat_flag,
    input logic       hangup,
    input logic       tx_fast,
    input logic       rx_fast,
    input phase_e     ph
);
    AST_SLAVE_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && turn_cmd && !role_master) |=> (ph != PH_FWD_WAIT)); // R1
    AST_FWD_HIGH_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FWD_WAIT) |-> tx_hi_sel); // R2
    AST_REV_LOW_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_REV_WAIT) |-> !tx_hi_sel); // R5
    AST_RETRY_HIGH_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_RETRY_WAIT) |-> tx_hi_sel); // R7
    AST_HANGUP_NOCAR: assert property (@(posedge clk) disable iff (!rst_n)
        hangup |-> (res_valid && res_code == 2'd3)); // R4
    AST_REV_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'd2) |-> stat_flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flag && !flag_clr) |=> stat_flag); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10
    AST_RATES_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fast != rx_fast); // R11
endmodule

bind v23_turn_ctrl v23_turn_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .turn_cmd   (turn_cmd),
    .role_master(role_master),
    .flag_clr   (flag_clr),
    .tx_hi_sel  (tx_hi_sel),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .stat_flag  (stat_flag),
    .hangup     (hangup),
    .tx_fast    (tx_fast),
    .rx_fast    (rx_fast),
    .ph         (q.ph)
);

// File: tb/tb_v23_turn_ctrl.sv
module tb_v23_turn_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, turn_cmd = 1'b0, role_master = 1'b0;
    logic car_lo = 1'b1, car_hi = 1'b0, flag_clr = 1'b0;
    logic tx_hi_sel, res_valid, stat_flag, hangup, tx_fast, rx_fast;
    logic [1:0] res_code;

    always #4 clk = ~clk;

    v23_turn_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .turn_cmd(turn_cmd),
        .role_master(role_master), .car_lo(car_lo), .car_hi(car_hi),
        .flag_clr(flag_clr), .tx_hi_sel(tx_hi_sel), .res_valid(res_valid),
        .res_code(res_code), .stat_flag(stat_flag), .hangup(hangup),
        .tx_fast(tx_fast), .rx_fast(rx_fast)
    );

    int n_chk = 0, n_fail = 0;
    int n_res = 0, n_hup = 0;
    int last_code = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 master, 2 slave first, 3 slave retry
    int m_mode = 0, m_cnt = 0, m_acc = 0, m_drop = 0, m_wl = 0;
    bit m_det, m_pass;
    bit e_hi = 0, e_vld = 0, e_flag = 0, e_hup = 0, e_txf = 0, e_rxf = 1;
    int e_code = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_acc = 0; m_drop = 0;
            e_hi = 0; e_vld = 0; e_flag = 0; e_hup = 0; e_txf = 0; e_rxf = 1; e_code = 0;
        end else begin
            e_vld = 0; e_hup = 0;
            if (flag_clr) e_flag = 0;
            if (m_mode == 0) begin
                e_hi = e_txf;
                if (role_master) begin
                    m_drop = 0;
                    if (turn_cmd) begin m_mode = 1; e_hi = 1; m_cnt = 0; m_acc = 0; end
                end else if (car_lo) begin
                    m_drop = 0;
                end else if (tick_ms) begin
                    m_drop++;
                    if (m_drop > 20) begin m_mode = 2; e_hi = 0; m_cnt = 0; m_acc = 0; m_drop = 0; end
                end
            end else if (tick_ms) begin
                m_det = (m_mode == 2) ? car_hi : car_lo;
                m_cnt++;
                if (m_det) m_acc++;
                m_wl = (m_mode == 1) ? 440 : (m_mode == 2) ? 400 : 440;
                if (m_cnt == m_wl) begin
                    m_pass = (m_acc > 40);
                    if (m_mode == 2 && !m_pass) begin
                        m_mode = 3; e_hi = 1; m_cnt = 0; m_acc = 0;
                    end else begin
                        e_vld = 1;
                        if (m_mode != 1) e_flag = 1;
                        if (m_pass) begin
                            e_code = (m_mode == 2) ? 2 : 1;
                            e_txf = e_hi; e_rxf = !e_hi;
                        end else begin
                            e_code = 3; e_hup = 1; e_hi = e_txf;
                        end
                        m_mode = 0;
                    end
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tx_hi_sel == e_hi, "R2 tx_hi_sel", tx_hi_sel, e_hi);
            check(res_valid == e_vld, "R10 res_valid", res_valid, e_vld);
            if (e_vld) check(res_code == e_code, "R3 res_code", res_code, e_code);
            check(hangup == e_hup, "R4 hangup", hangup, e_hup);
            check(stat_flag == e_flag, "R9 stat_flag", stat_flag, e_flag);
            check(tx_fast == e_txf && rx_fast == e_rxf, "R11 rate bits",
                  {tx_fast, rx_fast}, {e_txf, e_rxf});
            if (res_valid) begin n_res++; last_code = res_code; end
            if (hangup) n_hup++;
        end
    end

    // One tick every four clocks; tone active when i%step==0 and i/step < count
    task automatic run_ticks(int n, int lo_cnt, int lo_step, int hi_cnt, int hi_step);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            car_lo  = (i % lo_step == 0) && (i / lo_step < lo_cnt);
            car_hi  = (i % hi_step == 0) && (i / hi_step < hi_cnt);
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk); turn_cmd = 1'b1;
        @(negedge clk); turn_cmd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        int r0, h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_hi_sel == 0 && res_valid == 0 && stat_flag == 0, "R11 reset outputs",
              {tx_hi_sel, res_valid, stat_flag}, 0);
        check(tx_fast == 0 && rx_fast == 1, "R11 reset rates", {tx_fast, rx_fast}, 1);

        // R1: command in slave role ignored
        r0 = n_res;
        pulse_cmd();
        run_ticks(10, 10, 1, 0, 1);
        check(tx_hi_sel == 0, "R1 carrier unchanged", tx_hi_sel, 0);
        check(n_res == r0, "R1 no result", n_res - r0, 0);

        // R2/R3: master success with scattered tone (41 ticks, every 10th)
        role_master = 1'b1;
        r0 = n_res;
        pulse_cmd();
        @(negedge clk);
        check(tx_hi_sel == 1, "R2 high tone after command", tx_hi_sel, 1);
        run_ticks(439, 41, 10, 0, 1);
        check(n_res == r0, "R2 window not closed at 439", n_res - r0, 0);
        run_ticks(1, 0, 1, 0, 1);
        check(n_res == r0 + 1, "R10 one strobe", n_res - r0, 1);
        check(last_code == 1, "R3 forward connect code", last_code, 1);
        check(tx_fast == 1 && rx_fast == 0, "R11 rates after master", {tx_fast, rx_fast}, 2);

        // R4: exactly 40 ticks of tone fails
        r0 = n_res; h0 = n_hup;
        pulse_cmd();
        run_ticks(440, 40, 1, 0, 1);
        check(last_code == 3, "R4 no-carrier code", last_code, 3);
        check(n_hup == h0 + 1, "R4 hangup pulse", n_hup - h0, 1);
        check(tx_fast == 1, "R11 rates kept on failure", tx_fast, 1);

        // R5: drop recovers before limit, then reaches it
        role_master = 1'b0;
        @(negedge clk); car_lo = 1'b1;
        run_ticks(15, 0, 1, 0, 1);
        run_ticks(3, 3, 1, 0, 1);
        run_ticks(20, 0, 1, 0, 1);
        check(tx_hi_sel == 1, "R5 no reversal at 20 ticks", tx_hi_sel, 1);
        run_ticks(1, 0, 1, 0, 1);
        check(tx_hi_sel == 0, "R5 reversal at 21 ticks", tx_hi_sel, 0);

        // R6: first slave window succeeds
        run_ticks(400, 0, 1, 41, 1);
        @(negedge clk); car_lo = 1'b1;
        check(last_code == 2, "R6 reverse connect code", last_code, 2);
        check(stat_flag == 1, "R6 flag set", stat_flag, 1);
        check(tx_fast == 0 && rx_fast == 1, "R11 rates after slave", {tx_fast, rx_fast}, 1);
        repeat (10) @(negedge clk);
        check(stat_flag == 1, "R9 flag sticky", stat_flag, 1);
        pulse_clr();
        @(negedge clk);
        check(stat_flag == 0, "R9 flag cleared", stat_flag, 0);

        // R7: first window fails with exactly 40, retry succeeds
        run_ticks(21, 0, 1, 0, 1);
        run_ticks(400, 0, 1, 40, 1);
        check(tx_hi_sel == 1, "R7 carrier swapped back", tx_hi_sel, 1);
        run_ticks(440, 41, 1, 0, 1);
        @(negedge clk); car_lo = 1'b1;
        check(last_code == 1 && stat_flag == 1, "R7 retry connect", last_code, 1);
        check(tx_fast == 1, "R11 rates after retry", tx_fast, 1);
        pulse_clr();

        // R8: both slave windows fail
        h0 = n_hup;
        run_ticks(21, 0, 1, 0, 1);
        run_ticks(400, 0, 1, 5, 1);
        run_ticks(440, 40, 1, 0, 1);
        @(negedge clk); car_lo = 1'b1;
        check(last_code == 3 && stat_flag == 1, "R8 no-carrier with flag", last_code, 3);
        check(n_hup == h0 + 1, "R8 hangup pulse", n_hup - h0, 1);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule